// File: doc/BRIEF.md
# Real-Time Clock Host Register Port

This block sits between a host bus and the timekeeping logic of a real-time clock. The host reaches a 128-byte register and scratch space through two addresses. The first address selects a byte, and the second address reads or writes the byte that was selected. Four control and status bytes follow special rules: a control byte with a read-only busy flag, a mode byte whose freeze bit has side effects, a status byte that is cleared when it is read, and a constant byte that always reads back as valid.

The time counter, the alarm comparator and the periodic divider are separate blocks. This port gives them the stored control bytes, the seven time bytes and the three alarm bytes. It takes back interrupt flag strobes, busy-flag strobes and whole time snapshots from the counter. When the host releases the freeze bit, the port raises a one-cycle load pulse so that the counter takes the bytes the host has written.

Top module: `rtc_regport`

## Requirements
- R1: A host write with `hostSel`=0 loads the byte index from `hostWdata[6:0]`. A host read with `hostSel`=0 returns 0xFF.
- R2: A host read with `hostSel`=1 returns the byte at the current index, with no wait cycle. A host write with `hostSel`=1 to any index outside 10..13 stores the data there. After reset the scratch and time bytes read 0x00.
- R3: After reset, index 10 (control) reads 0x26, index 11 (mode) reads 0x02, index 12 (status) reads 0x00, index 13 (valid) reads 0x80, and `irqReq` is low.
- R4: A data read of index 12 returns the status byte and then clears it to 0x00, which drops `irqReq`. A flag strobe that arrives in the same cycle as that read is kept.
- R5: Host writes to index 12 and index 13 leave both bytes unchanged.
- R6: Bit 7 of index 10 (busy) ignores host writes, while bits 6:0 take the written data. `uipSet` sets busy unless the freeze bit is high. `uipClr` clears busy. The freeze-write clear of R7 has priority over `uipSet`, and `uipSet` has priority over `uipClr`.
- R7: A host write to index 11 with bit 7 (freeze) high clears busy and stores bit 4 (update interrupt enable) as 0.
- R8: A host write to index 11 with bit 7 low, made while freeze was high, raises `loadStrobe` for exactly one cycle, starting the cycle after the write.
- R9: In the status byte, `flagPer` sets bits 7 and 6, `flagAlm` sets bits 7 and 5, and `flagUpd` sets bits 7 and 4. `irqReq` follows bit 7, one cycle after the strobe.
- R10: `cntWr` loads `cntTime` into the time bytes: byte 0 goes to index 0, byte 1 to index 2, byte 2 to index 4, byte 3 to index 6, byte 4 to index 7, byte 5 to index 8 and byte 6 to index 9. It is ignored while freeze is high. A host data write to the same index in the same cycle wins.
- R11: `ctrlA` and `ctrlB` mirror indices 10 and 11. `timeRegs` packs the time bytes in the order of R10. `alarmRegs` packs indices 1, 3 and 5 as bytes 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | 0 selects the index address, 1 selects the data address |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data, combinational |
| flagPer | input | 1 | Periodic interrupt flag strobe |
| flagAlm | input | 1 | Alarm interrupt flag strobe |
| flagUpd | input | 1 | Update-ended interrupt flag strobe |
| uipSet | input | 1 | Counter strobe that sets the busy flag |
| uipClr | input | 1 | Counter strobe that clears the busy flag |
| cntWr | input | 1 | Counter snapshot write strobe |
| cntTime | input | 56 | Counter snapshot of the seven time bytes |
| ctrlA | output | 8 | Control byte (index 10) |
| ctrlB | output | 8 | Mode byte (index 11) |
| timeRegs | output | 56 | Seven stored time bytes |
| alarmRegs | output | 24 | Three stored alarm bytes |
| loadStrobe | output | 1 | One-cycle pulse when freeze is released |
| irqReq | output | 1 | Interrupt request, equal to status bit 7 |

## Verification
The checker watches the rules that hold on every cycle. It confirms that index-port reads return 0xFF and that any flag strobe raises the request. It confirms that the request only falls after a data read, and that the load pulse only follows a falling freeze bit. It also confirms that a stored freeze bit never sits beside a set update-enable bit, that a counter snapshot leaves the time bytes alone while frozen, and that busy only rises on an allowed strobe. Only the bench scenarios can show which index a value lands at, clear-on-read that keeps a same-cycle flag, the write-protect of the status and valid bytes, and priority between a host write and a snapshot to the same byte.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = 7;
  localparam int DEPTH     = 1 << IDX_W;
  localparam int NUM_TIME  = 7;
  localparam int NUM_ALARM = 3;
  localparam int NUM_FLAG  = 3;

  localparam logic [IDX_W-1:0] IDX_CTRL   = 7'd10;
  localparam logic [IDX_W-1:0] IDX_MODE   = 7'd11;
  localparam logic [IDX_W-1:0] IDX_STATUS = 7'd12;
  localparam logic [IDX_W-1:0] IDX_VALID  = 7'd13;

  localparam logic [DATA_W-1:0] RST_CTRL  = 8'h26;
  localparam logic [DATA_W-1:0] RST_MODE  = 8'h02;
  localparam logic [DATA_W-1:0] VAL_VALID = 8'h80;
  localparam logic [DATA_W-1:0] IDX_READ  = 8'hFF;

  localparam int BUSY_BIT   = 7;
  localparam int FREEZE_BIT = 7;
  localparam int UPDEN_BIT  = 4;
  localparam int IRQ_BIT    = 7;

  // Time byte k lives at this index; the counter's snapshot order follows it.
  function automatic logic [IDX_W-1:0] timeIdx(input int k);
    case (k)
      0: timeIdx = 7'd0;
      1: timeIdx = 7'd2;
      2: timeIdx = 7'd4;
      3: timeIdx = 7'd6;
      4: timeIdx = 7'd7;
      5: timeIdx = 7'd8;
      default: timeIdx = 7'd9;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] alarmIdx(input int k);
    alarmIdx = IDX_W'(2 * k + 1);
  endfunction

  typedef struct packed {
    logic                idxLoad;
    logic                memWr;
    logic                ctrlWr;
    logic                modeWr;
    logic [DATA_W-1:0]   modeVal;
    logic                busyForceClr;
    logic                busySet;
    logic                busyClr;
    logic                statClr;
    logic [NUM_FLAG-1:0] flagSet;   // {periodic, alarm, update}
    logic                snapWr;
  } rtcStrb_t;
endpackage

// File: rtl/rtc_regport_ctrl.sv
module rtc_regport_ctrl
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [IDX_W-1:0]  curIdx,
  input  logic [DATA_W-1:0] curMode,
  input  logic              flagPer,
  input  logic              flagAlm,
  input  logic              flagUpd,
  input  logic              uipSet,
  input  logic              uipClr,
  input  logic              cntWr,
  output rtcStrb_t          strb,
  output logic              loadStrobe
);
  logic dataWr;
  logic specialIdx;
  logic frozen;
  logic freezeReq;

  always_comb begin
    dataWr     = hostWr & hostSel;
    specialIdx = (curIdx >= IDX_CTRL) && (curIdx <= IDX_VALID);
    frozen     = curMode[FREEZE_BIT];
    freezeReq  = hostWdata[FREEZE_BIT];

    strb              = '0;
    strb.idxLoad      = hostWr & ~hostSel;
    strb.memWr        = dataWr & ~specialIdx;
    strb.ctrlWr       = dataWr & (curIdx == IDX_CTRL);
    strb.modeWr       = dataWr & (curIdx == IDX_MODE);
    strb.modeVal      = hostWdata;
    if (freezeReq) strb.modeVal[UPDEN_BIT] = 1'b0;
    strb.busyForceClr = strb.modeWr & freezeReq;
    strb.busySet      = uipSet & ~frozen;
    strb.busyClr      = uipClr;
    strb.statClr      = hostRd & hostSel & (curIdx == IDX_STATUS);
    strb.flagSet      = {flagPer, flagAlm, flagUpd};
    strb.snapWr       = cntWr & ~frozen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) loadStrobe <= 1'b0;
    else       loadStrobe <= dataWr & (curIdx == IDX_MODE) & ~freezeReq & frozen;
  end
endmodule

// File: rtl/rtc_regport_dp.sv
module rtc_regport_dp
  import rtc_regport_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  rtcStrb_t                    strb,
  input  logic                        hostSel,
  input  logic [DATA_W-1:0]           hostWdata,
  input  logic [NUM_TIME*DATA_W-1:0]  cntTime,
  output logic [DATA_W-1:0]           hostRdata,
  output logic [IDX_W-1:0]            curIdx,
  output logic [DATA_W-1:0]           ctrlReg,
  output logic [DATA_W-1:0]           modeReg,
  output logic [DATA_W-1:0]           statReg,
  output logic [NUM_TIME*DATA_W-1:0]  timeRegs,
  output logic [NUM_ALARM*DATA_W-1:0] alarmRegs
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] statNext;
  logic              anyFlag;

  always_ff @(posedge clk) begin
    if (!rstN) curIdx <= '0;
    else if (strb.idxLoad) curIdx <= hostWdata[IDX_W-1:0];
  end

  // Snapshot first, host write last, so a host write to the same byte wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.snapWr)
        for (int k = 0; k < NUM_TIME; k++)
          mem[timeIdx(k)] <= cntTime[k*DATA_W +: DATA_W];
      if (strb.memWr) mem[curIdx] <= hostWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= RST_CTRL;
    end else begin
      if (strb.ctrlWr) ctrlReg[BUSY_BIT-1:0] <= hostWdata[BUSY_BIT-1:0];
      if (strb.busyForceClr)  ctrlReg[BUSY_BIT] <= 1'b0;
      else if (strb.busySet)  ctrlReg[BUSY_BIT] <= 1'b1;
      else if (strb.busyClr)  ctrlReg[BUSY_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= RST_MODE;
    else if (strb.modeWr) modeReg <= strb.modeVal;
  end

  always_comb begin
    anyFlag  = |strb.flagSet;
    statNext = strb.statClr ? '0 : statReg;
    statNext = statNext | {anyFlag, strb.flagSet, {(DATA_W-1-NUM_FLAG){1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) statReg <= '0;
    else       statReg <= statNext;
  end

  always_comb begin
    if (!hostSel) begin
      hostRdata = IDX_READ;
    end else begin
      case (curIdx)
        IDX_CTRL:   hostRdata = ctrlReg;
        IDX_MODE:   hostRdata = modeReg;
        IDX_STATUS: hostRdata = statReg;
        IDX_VALID:  hostRdata = VAL_VALID;
        default:    hostRdata = mem[curIdx];
      endcase
    end
  end

  for (genvar k = 0; k < NUM_TIME; k++) begin : g_time
    assign timeRegs[k*DATA_W +: DATA_W] = mem[timeIdx(k)];
  end
  for (genvar k = 0; k < NUM_ALARM; k++) begin : g_alarm
    assign alarmRegs[k*DATA_W +: DATA_W] = mem[alarmIdx(k)];
  end
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hostSel,
  input  logic                        hostWr,
  input  logic                        hostRd,
  input  logic [DATA_W-1:0]           hostWdata,
  output logic [DATA_W-1:0]           hostRdata,
  input  logic                        flagPer,
  input  logic                        flagAlm,
  input  logic                        flagUpd,
  input  logic                        uipSet,
  input  logic                        uipClr,
  input  logic                        cntWr,
  input  logic [NUM_TIME*DATA_W-1:0]  cntTime,
  output logic [DATA_W-1:0]           ctrlA,
  output logic [DATA_W-1:0]           ctrlB,
  output logic [NUM_TIME*DATA_W-1:0]  timeRegs,
  output logic [NUM_ALARM*DATA_W-1:0] alarmRegs,
  output logic                        loadStrobe,
  output logic                        irqReq
);
  rtcStrb_t          strb;
  logic [IDX_W-1:0]  curIdx;
  logic [DATA_W-1:0] statReg;

  rtc_regport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .curIdx(curIdx), .curMode(ctrlB),
    .flagPer(flagPer), .flagAlm(flagAlm), .flagUpd(flagUpd),
    .uipSet(uipSet), .uipClr(uipClr), .cntWr(cntWr),
    .strb(strb), .loadStrobe(loadStrobe)
  );

  rtc_regport_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostSel(hostSel), .hostWdata(hostWdata),
    .cntTime(cntTime), .hostRdata(hostRdata), .curIdx(curIdx),
    .ctrlReg(ctrlA), .modeReg(ctrlB), .statReg(statReg),
    .timeRegs(timeRegs), .alarmRegs(alarmRegs)
  );

  assign irqReq = statReg[IRQ_BIT];
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk
  import rtc_regport_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        hostSel,
  input logic                        hostWr,
  input logic                        hostRd,
  input logic [DATA_W-1:0]           hostRdata,
  input logic                        flagPer,
  input logic                        flagAlm,
  input logic                        flagUpd,
  input logic                        uipSet,
  input logic                        cntWr,
  input logic [DATA_W-1:0]           ctrlA,
  input logic [DATA_W-1:0]           ctrlB,
  input logic [NUM_TIME*DATA_W-1:0]  timeRegs,
  input logic                        loadStrobe,
  input logic                        irqReq
);
  // R1
  idx_read_ff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostSel) |-> hostRdata == IDX_READ);

  // R9
  flag_raises_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagPer || flagAlm || flagUpd) |=> irqReq);

  // R4
  irq_drop_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqReq) |-> $past(hostRd && hostSel));

  // R8
  load_after_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |-> ($past(ctrlB[FREEZE_BIT]) && !ctrlB[FREEZE_BIT]));

  // R7
  freeze_no_upden_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlB[FREEZE_BIT] |-> !ctrlB[UPDEN_BIT]);

  // R10
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntWr && ctrlB[FREEZE_BIT] && !hostWr) |-> $stable(timeRegs));

  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlA[BUSY_BIT]) |-> ($past(uipSet) && !$past(ctrlB[FREEZE_BIT])));
endmodule

bind rtc_regport rtc_regport_chk u_chk (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
  .hostRdata(hostRdata), .flagPer(flagPer), .flagAlm(flagAlm), .flagUpd(flagUpd),
  .uipSet(uipSet), .cntWr(cntWr), .ctrlA(ctrlA), .ctrlB(ctrlB),
  .timeRegs(timeRegs), .loadStrobe(loadStrobe), .irqReq(irqReq)
);

// File: tb/sim_rtc_regport.sv
module sim_rtc_regport;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        flagPer = 1'b0, flagAlm = 1'b0, flagUpd = 1'b0;
  logic        uipSet = 1'b0, uipClr = 1'b0, cntWr = 1'b0;
  logic [55:0] cntTime = '0;
  logic [7:0]  ctrlA, ctrlB;
  logic [55:0] timeRegs;
  logic [23:0] alarmRegs;
  logic        loadStrobe, irqReq;

  int total = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] expMem [128];
  logic [7:0] expA, expB, expC;
  logic [6:0] expIdx;
  logic       expLoad;

  always #5 clk = ~clk;

  rtc_regport u0 (.*);

  function automatic logic [6:0] tIdx(input int k);
    logic [6:0] tab [7] = '{7'd0, 7'd2, 7'd4, 7'd6, 7'd7, 7'd8, 7'd9};
    return tab[k];
  endfunction

  function automatic logic [7:0] expRead(input logic sel);
    if (!sel) return 8'hFF;
    case (expIdx)
      7'd10: return expA;
      7'd11: return expB;
      7'd12: return expC;
      7'd13: return 8'h80;
      default: return expMem[expIdx];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 128; i++) expMem[i] = 8'h00;
    expA = 8'h26; expB = 8'h02; expC = 8'h00; expIdx = '0; expLoad = 0;
  endtask

  task automatic modelStep(input logic sel, wr, rd, input logic [7:0] wd, input logic [2:0] fl,
                           input logic uS, uC, cW, input logic [55:0] ct);
    logic [7:0] oldB = expB;
    bit busyKill = 0;
    bit memHit = 0;
    logic [6:0] oldIdx = expIdx;
    expLoad = 0;
    if (wr && !sel) expIdx = wd[6:0];
    if (wr && sel) begin
      case (oldIdx)
        7'd10: expA[6:0] = wd[6:0];
        7'd11: begin
          if (wd[7]) begin busyKill = 1; expB = wd & 8'hEF; end
          else begin expLoad = oldB[7]; expB = wd; end
        end
        7'd12, 7'd13: ;
        default: memHit = 1;
      endcase
    end
    if (cW && !oldB[7])
      for (int k = 0; k < 7; k++) expMem[tIdx(k)] = ct[k*8 +: 8];
    if (memHit) expMem[oldIdx] = wd;
    if (busyKill) expA[7] = 0;
    else if (uS && !oldB[7]) expA[7] = 1;
    else if (uC) expA[7] = 0;
    if (rd && sel && oldIdx == 7'd12) expC = 8'h00;
    if (fl[2]) expC = expC | 8'hC0;
    if (fl[1]) expC = expC | 8'hA0;
    if (fl[0]) expC = expC | 8'h90;
  endtask

  task automatic step(input logic sel, wr, rd, input logic [7:0] wd, input logic [2:0] fl,
                      input logic uS, uC, cW, input logic [55:0] ct);
    logic [55:0] expT;
    logic [23:0] expAl;
    string rtag;
    @(negedge clk);
    hostSel = sel; hostWr = wr; hostRd = rd; hostWdata = wd;
    {flagPer, flagAlm, flagUpd} = fl; uipSet = uS; uipClr = uC; cntWr = cW; cntTime = ct;
    #1;
    if (rd) begin
      rtag = !sel ? "R1" : (expIdx == 7'd12) ? "R4" : (expIdx >= 7'd10 && expIdx <= 7'd13) ? "R3" : "R2";
      check(hostRdata === expRead(sel), rtag, 64'(hostRdata), 64'(expRead(sel)));
    end
    @(posedge clk);
    #1;
    modelStep(sel, wr, rd, wd, fl, uS, uC, cW, ct);
    hostWr = 0; hostRd = 0; flagPer = 0; flagAlm = 0; flagUpd = 0;
    uipSet = 0; uipClr = 0; cntWr = 0;
    for (int k = 0; k < 7; k++) expT[k*8 +: 8] = expMem[tIdx(k)];
    for (int k = 0; k < 3; k++) expAl[k*8 +: 8] = expMem[2*k+1];
    check(loadStrobe === expLoad, "R8", 64'(loadStrobe), 64'(expLoad));
    check(irqReq === expC[7], "R9", 64'(irqReq), 64'(expC[7]));
    check(ctrlA === expA, "R6", 64'(ctrlA), 64'(expA));
    check(ctrlB === expB, "R7", 64'(ctrlB), 64'(expB));
    check(timeRegs === expT, "R10", 64'(timeRegs), 64'(expT));
    check(alarmRegs === expAl, "R11", 64'(alarmRegs), 64'(expAl));
  endtask

  task automatic setIdx(input logic [7:0] i); step(0, 1, 0, i, 3'b0, 0, 0, 0, '0); endtask
  task automatic wrData(input logic [7:0] d); step(1, 1, 0, d, 3'b0, 0, 0, 0, '0); endtask
  task automatic rdData(); step(1, 0, 1, 8'h0, 3'b0, 0, 0, 0, '0); endtask
  task automatic idle(input logic [2:0] fl, input logic uS, uC, cW, input logic [55:0] ct);
    step(0, 0, 0, 8'h0, fl, uS, uC, cW, ct);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R3 reset values
    for (int i = 10; i < 14; i++) begin setIdx(8'(i)); rdData(); end
    setIdx(8'd40); rdData();                        // R2 storage resets to zero
    // R1 index port reads 0xFF; bit 7 of index data ignored
    step(0, 0, 1, 8'h0, 3'b0, 0, 0, 0, '0);
    setIdx(8'hB2); wrData(8'h5A); setIdx(8'd50); rdData(); // R2 at 0x32
    // R5 status and valid ignore writes
    setIdx(8'd12); wrData(8'hFF); rdData();
    setIdx(8'd13); wrData(8'h00); rdData();
    // R6 busy read-only, strobes
    setIdx(8'd10); wrData(8'hFF); rdData();
    idle(3'b0, 1, 0, 0, '0); wrData(8'h00); rdData();
    idle(3'b0, 1, 1, 0, '0); idle(3'b0, 0, 1, 0, '0);
    idle(3'b0, 1, 0, 0, '0);
    // R7 freeze write clears busy and update enable
    setIdx(8'd11); wrData(8'hF2); rdData();
    idle(3'b0, 1, 0, 0, '0);                        // R6 set ignored while frozen
    idle(3'b0, 0, 0, 1, 56'h11223344556677);        // R10 ignored while frozen
    setIdx(8'd4); wrData(8'h12);
    setIdx(8'd11); wrData(8'h12);                   // R8 release pulses load
    idle(3'b0, 0, 0, 0, '0);
    wrData(8'h02);                                   // R8 no pulse when not frozen
    idle(3'b0, 0, 0, 1, 56'h09081706050403);        // R10 snapshot applies
    setIdx(8'd2); step(1, 1, 0, 8'hAB, 3'b0, 0, 0, 1, 56'hFFFFFFFFFFFFFF); // R10 host wins
    rdData();
    setIdx(8'd3); wrData(8'h33);                    // R11 alarm byte
    // R9 flags and R4 clear-on-read
    idle(3'b100, 0, 0, 0, '0); idle(3'b010, 0, 0, 0, '0);
    setIdx(8'd12); rdData(); rdData();
    idle(3'b001, 0, 0, 0, '0);
    step(1, 0, 1, 8'h0, 3'b100, 0, 0, 0, '0);       // R4 same-cycle flag kept
    rdData();
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 15));
      logic [2:0] fl = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b0;
      logic uS = ($urandom_range(0, 5) == 0);
      logic uC = ($urandom_range(0, 5) == 0);
      logic cW = ($urandom_range(0, 5) == 0);
      logic [55:0] ct = {24'($urandom), 32'($urandom)};
      case (op)
        0, 1, 2: step(0, 1, 0, d, fl, uS, uC, cW, ct);
        3, 4:    step(1, 1, 0, 8'($urandom), fl, uS, uC, cW, ct);
        5, 6, 7: step(1, 0, 1, 8'h0, fl, uS, uC, cW, ct);
        8:       step(0, 0, 1, 8'h0, fl, uS, uC, cW, ct);
        default: step(0, 0, 0, 8'h0, fl, uS, uC, cW, ct);
      endcase
    end
    finishRun();
  end
endmodule